// File: doc/BRIEF.md
# Character LCD Console Controller

This block turns a byte stream into text on a two-row, sixteen-column character display. The display sits behind an 8-bit register port with two registers. The data register is at select 0. A shared control register is at select 1: a write to it is a command, and a read from it returns the status. Bytes arrive over a valid/ready handshake. The block keeps two sixteen-character line buffers. Printable bytes are placed into the current line until it is full, and a newline repaints the whole display so that the text scrolls upward like a terminal.

The display's internal controller is slow. Every access to it is therefore guarded. The block polls the busy bit in the status register until it clears, then performs one more status read as a settling margin, and only then issues the write. After reset the block configures the display on its own, blanks both rows, and then raises a completion flag and starts to accept bytes.

Top module: `lcd_console`

## Requirements
- R1: Before every register write the block reads the control register (select 1) repeatedly until a read returns bit 7 = 0. It then issues exactly one further control-register read, and the write follows after that. Read data is taken one cycle after the read strobe.
- R2: After reset the block writes command 0x38, then command 0x0C, then repaints two blank rows. Only then does `init_done` rise, and it stays high until the next reset.
- R3: A repaint writes command 0x80 followed by the 16 characters of the top row as data. It then writes command 0xC0 (0x80 + 0x40) followed by the 16 characters of the bottom row.
- R4: Command writes use select 1 and data writes use select 0. A read and a write never happen in the same cycle.
- R5: A byte that is neither 0x0D nor 0x0A is stored at the next free position of the current line. Once 16 characters are on the line, further such bytes are dropped.
- R6: A carriage return (0x0D) is accepted but changes nothing: it causes no bus traffic and takes no position on the line.
- R7: A newline (0x0A) repaints the display with the previous line on the top row and the current line on the bottom row. After the repaint the current line index toggles, the position returns to 0, and the new current line is blank.
- R8: `in_ready` is low during initialisation and during a repaint. Accepting a byte other than a newline causes no bus traffic.
- R9: During reset no register access is made, and `in_ready` and `init_done` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_byte | input | 8 | Input character |
| in_ready | output | 1 | Block can take a byte |
| reg_sel | output | 1 | Register select: 0 data, 1 command/status |
| reg_wr | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rd | output | 1 | Register read strobe |
| reg_rdata | input | 8 | Read data, valid one cycle after `reg_rd`; bit 7 is busy |
| init_done | output | 1 | Power-up configuration finished |

## Verification
The bench acts as the display and varies how many busy reads it answers before each write, including zero, so the read count before every write shows whether the poll loop exits at the right time and whether the single settling read is present. The byte streams cover a short line, a line mixed with carriage returns, a line of 20 characters, a line of exactly 16 characters, and newlines sent back to back. The mixed line shows that a carriage return takes no position. The long line shows that the 17th and later characters are dropped. The exact-fit line checks the boundary. The back-to-back newlines show that the rows swap and that a new line starts blank. The reference model predicts the whole sequence of writes, and each write is compared against it.

// File: rtl/lcd_con_pkg.sv
package lcd_con_pkg;

    localparam logic [7:0] OP_FUNC_SET   = 8'h38;
    localparam logic [7:0] OP_DISPLAY_ON = 8'h0C;
    localparam logic [7:0] OP_SET_ADDR   = 8'h80;
    localparam logic [7:0] ROW1_START    = 8'h40;

    localparam logic [7:0] ASCII_CR    = 8'h0D;
    localparam logic [7:0] ASCII_LF    = 8'h0A;
    localparam logic [7:0] ASCII_SPACE = 8'h20;

    localparam int unsigned BUSY_BIT = 7;

    localparam logic SEL_DATA = 1'b0;
    localparam logic SEL_CTRL = 1'b1;

    typedef struct packed {
        logic       is_data;
        logic [7:0] value;
    } port_op_t;

    typedef enum logic [2:0] {
        AX_IDLE,
        AX_POLL,
        AX_POLL_CHK,
        AX_SPARE,
        AX_SPARE_WAIT,
        AX_WRITE
    } ax_state_t;

    typedef enum logic [2:0] {
        CS_FUNC,
        CS_DISP_ON,
        CS_ROW_ADDR,
        CS_ROW_DATA,
        CS_READY
    } con_state_t;

    function automatic logic [7:0] row_addr_cmd(input logic row);
        return OP_SET_ADDR | (row ? ROW1_START : 8'h00);
    endfunction

endpackage

// File: rtl/lcd_port_access.sv
module lcd_port_access
    import lcd_con_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  port_op_t op,
    output logic     done,
    input  logic     busy_in,
    output logic     bus_sel,
    output logic     bus_wr,
    output logic [7:0] bus_wdata,
    output logic     bus_rd
);

    ax_state_t state_q, state_d;

    always_comb begin
        state_d   = state_q;
        done      = 1'b0;
        bus_sel   = SEL_CTRL;
        bus_wr    = 1'b0;
        bus_rd    = 1'b0;
        bus_wdata = 8'h00;
        unique case (state_q)
            AX_IDLE: if (req) state_d = AX_POLL;
            AX_POLL: begin
                bus_rd  = 1'b1;
                state_d = AX_POLL_CHK;
            end
            AX_POLL_CHK: state_d = busy_in ? AX_POLL : AX_SPARE;
            AX_SPARE: begin
                bus_rd  = 1'b1;
                state_d = AX_SPARE_WAIT;
            end
            AX_SPARE_WAIT: state_d = AX_WRITE;
            AX_WRITE: begin
                bus_wr    = 1'b1;
                bus_sel   = op.is_data ? SEL_DATA : SEL_CTRL;
                bus_wdata = op.value;
                done      = 1'b1;
                state_d   = AX_IDLE;
            end
            default: state_d = AX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= AX_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/lcd_line_store.sv
module lcd_line_store
    import lcd_con_pkg::*;
#(
    parameter int unsigned COLS = 16,
    localparam int unsigned IW = $clog2(COLS),
    localparam int unsigned PW = $clog2(COLS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_char,
    input  logic          commit_nl,
    input  logic          rd_line,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_char,
    output logic          cur_line
);

    logic [7:0]    rows [2][COLS];
    logic          cur_q;
    logic [PW-1:0] pos_q;

    assign cur_line = cur_q;
    assign rd_char  = rows[rd_line][rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= 1'b0;
            pos_q <= '0;
            for (int l = 0; l < 2; l++)
                for (int c = 0; c < COLS; c++)
                    rows[l][c] <= ASCII_SPACE;
        end else if (commit_nl) begin
            cur_q <= ~cur_q;
            pos_q <= '0;
            for (int c = 0; c < COLS; c++)
                rows[~cur_q][c] <= ASCII_SPACE;
        end else if (push && pos_q < PW'(COLS)) begin
            rows[cur_q][pos_q[IW-1:0]] <= push_char;
            pos_q <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_console.sv
module lcd_console
    import lcd_con_pkg::*;
#(
    parameter int unsigned COLS = 16,
    localparam int unsigned IW = $clog2(COLS)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       in_ready,
    output logic       reg_sel,
    output logic       reg_wr,
    output logic [7:0] reg_wdata,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata,
    output logic       init_done
);

    con_state_t    state_q;
    logic          row_q;
    logic [IW-1:0] col_q;
    logic          nl_pending_q;
    logic          done_q;

    logic          req;
    port_op_t      op;
    logic          ax_done;
    logic          accept;
    logic          push;
    logic          commit_nl;
    logic          last_char;
    logic [7:0]    rd_char;
    logic          cur_line;
    logic          rd_line;
    logic          unused_status_bits;

    assign unused_status_bits = ^reg_rdata[BUSY_BIT-1:0];

    assign in_ready  = (state_q == CS_READY);
    assign init_done = done_q;
    assign accept    = in_valid && in_ready;
    assign push      = accept && in_byte != ASCII_CR && in_byte != ASCII_LF;
    assign last_char = (state_q == CS_ROW_DATA) && (col_q == IW'(COLS - 1));
    assign commit_nl = ax_done && last_char && row_q && nl_pending_q;
    assign rd_line   = row_q ? cur_line : ~cur_line;

    always_comb begin
        req = 1'b1;
        op  = '{is_data: 1'b0, value: 8'h00};
        unique case (state_q)
            CS_FUNC:     op = '{is_data: 1'b0, value: OP_FUNC_SET};
            CS_DISP_ON:  op = '{is_data: 1'b0, value: OP_DISPLAY_ON};
            CS_ROW_ADDR: op = '{is_data: 1'b0, value: row_addr_cmd(row_q)};
            CS_ROW_DATA: op = '{is_data: 1'b1, value: rd_char};
            default:     req = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CS_FUNC;
            row_q        <= 1'b0;
            col_q        <= '0;
            nl_pending_q <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            unique case (state_q)
                CS_FUNC:    if (ax_done) state_q <= CS_DISP_ON;
                CS_DISP_ON: if (ax_done) begin
                    state_q <= CS_ROW_ADDR;
                    row_q   <= 1'b0;
                end
                CS_ROW_ADDR: if (ax_done) begin
                    state_q <= CS_ROW_DATA;
                    col_q   <= '0;
                end
                CS_ROW_DATA: if (ax_done) begin
                    if (!last_char) begin
                        col_q <= col_q + 1'b1;
                    end else if (!row_q) begin
                        row_q   <= 1'b1;
                        state_q <= CS_ROW_ADDR;
                    end else begin
                        state_q      <= CS_READY;
                        done_q       <= 1'b1;
                        nl_pending_q <= 1'b0;
                    end
                end
                CS_READY: if (accept && in_byte == ASCII_LF) begin
                    state_q      <= CS_ROW_ADDR;
                    row_q        <= 1'b0;
                    nl_pending_q <= 1'b1;
                end
                default: state_q <= CS_FUNC;
            endcase
        end
    end

    lcd_port_access i_access (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .op        (op),
        .done      (ax_done),
        .busy_in   (reg_rdata[BUSY_BIT]),
        .bus_sel   (reg_sel),
        .bus_wr    (reg_wr),
        .bus_wdata (reg_wdata),
        .bus_rd    (reg_rd)
    );

    lcd_line_store #(.COLS(COLS)) i_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_char (in_byte),
        .commit_nl (commit_nl),
        .rd_line   (rd_line),
        .rd_idx    (col_q),
        .rd_char   (rd_char),
        .cur_line  (cur_line)
    );

endmodule

// File: rtl/lcd_console_chk.sv
module lcd_console_chk (
    input logic       clk,
    input logic       rst,
    input logic       in_ready,
    input logic       reg_sel,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_rdata,
    input logic       init_done
);

    // R1: a write follows a not-busy status result and one settling read
    p_guarded_write_r1: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> ($past(reg_rd, 2) && $past(reg_sel, 2) && $past(reg_rd, 4)
                    && !$past(reg_rdata[7], 3)));

    // R1: status reads only target the control register
    p_read_ctrl_r1: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> reg_sel);

    // R4: no read and write in one cycle
    p_no_clash_r4: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));

    // R2: ready only after configuration
    p_ready_after_init_r2: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> init_done);

    // R2: completion flag holds
    p_init_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    // R8: the port is quiet while bytes are taken
    p_quiet_ready_r8: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (!reg_wr && !reg_rd));

endmodule

bind lcd_console lcd_console_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_ready  (in_ready),
    .reg_sel   (reg_sel),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .init_done (init_done)
);

// File: tb/test_lcd_console.sv
module test_lcd_console;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       in_ready;
    logic       reg_sel;
    logic       reg_wr;
    logic [7:0] reg_wdata;
    logic       reg_rd;
    logic [7:0] reg_rdata;
    logic       init_done;

    always #10 clk = ~clk;

    lcd_console i_lcd_console (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .in_ready  (in_ready),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .init_done (init_done)
    );

    int nchk = 0;
    int nfail = 0;

    // reference model
    logic [8:0] expq[$];
    logic [7:0] lines [2][16];
    int cur = 0;
    int pos = 0;

    // display responder
    int busy_cnt;
    int reads_since;
    int exp_reads;
    int wr_count;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic model_repaint();
        for (int r = 0; r < 2; r++) begin
            int ln = (r == 0) ? (cur ^ 1) : cur;
            expq.push_back({1'b1, (r == 0) ? 8'h80 : 8'hC0});
            for (int c = 0; c < 16; c++) expq.push_back({1'b0, lines[ln][c]});
        end
    endtask

    task automatic model_apply(input logic [7:0] b);
        if (b == 8'h0D) return;
        if (b == 8'h0A) begin
            model_repaint();
            cur = cur ^ 1;
            pos = 0;
            for (int c = 0; c < 16; c++) lines[cur][c] = 8'h20;
        end else if (pos < 16) begin
            lines[cur][pos] = b;
            pos++;
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            busy_cnt    <= 2;
            reads_since <= 0;
            exp_reads   <= 4;
            wr_count    <= 0;
            reg_rdata   <= 8'h00;
        end else if (reg_wr) begin
            busy_cnt    <= ((wr_count + 1) * 3) % 4;
            exp_reads   <= ((wr_count + 1) * 3) % 4 + 2;
            reads_since <= 0;
            wr_count    <= wr_count + 1;
        end else if (reg_rd) begin
            reads_since <= reads_since + 1;
            reg_rdata   <= {busy_cnt != 0, 7'h05};
            if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr) begin
                chk(reads_since == exp_reads, "R1", "status reads before write",
                    reads_since, exp_reads);
                if (expq.size() == 0) begin
                    chk(1'b0, "R8", "unexpected write", {reg_sel, reg_wdata}, 0);
                end else begin
                    logic [8:0] e;
                    e = expq.pop_front();
                    chk({reg_sel, reg_wdata} == e, "R3 R4 R5 R7", "write sel/data",
                        {reg_sel, reg_wdata}, e);
                end
            end
            if (expq.size() != 0)
                chk(!in_ready, "R8", "in_ready while writes pending", in_ready, 0);
        end
    end

    task automatic send_byte(input logic [7:0] b);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_byte  = b;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        model_apply(b);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_str(input string s);
        for (int i = 0; i < s.len(); i++) send_byte(s[i]);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(in_ready && expq.size() == 0));
    endtask

    initial begin
        for (int l = 0; l < 2; l++)
            for (int c = 0; c < 16; c++) lines[l][c] = 8'h20;
        expq.push_back({1'b1, 8'h38});
        expq.push_back({1'b1, 8'h0C});
        model_repaint();

        repeat (3) @(negedge clk);
        chk(!in_ready, "R9", "in_ready in reset", in_ready, 0);
        chk(!init_done, "R9", "init_done in reset", init_done, 0);
        chk(!reg_wr && !reg_rd, "R9", "bus idle in reset", {reg_wr, reg_rd}, 0);
        @(posedge clk);
        #1 rst = 1'b0;

        @(negedge clk);
        chk(!init_done, "R2", "init_done before configuration", init_done, 0);
        wait_idle();
        chk(init_done, "R2", "init_done after configuration", init_done, 1);

        // short line
        send_str("Hi");
        send_byte(8'h0A);
        wait_idle();

        // carriage returns take nothing
        begin
            int w0;
            w0 = wr_count;
            send_byte("A");
            send_byte(8'h0D);
            send_byte("B");
            send_byte(8'h0D);
            repeat (30) @(negedge clk);
            chk(wr_count == w0, "R6", "writes after CR/printables", wr_count, w0);
            chk(in_ready, "R6", "ready after CR", in_ready, 1);
        end
        send_byte(8'h0A);
        wait_idle();

        // overflow: 20 characters, only 16 kept
        for (int i = 0; i < 20; i++) send_byte(8'h61 + i);
        send_byte(8'h0A);
        wait_idle();

        // back-to-back newlines scroll blank lines
        send_byte(8'h0A);
        send_byte(8'h0A);
        wait_idle();

        // exact fit
        send_str("0123456789ABCDEF");
        send_byte(8'h0D);
        send_byte(8'h0A);
        wait_idle();

        repeat (10) @(negedge clk);
        chk(expq.size() == 0, "R7", "pending writes at end", expq.size(), 0);
        chk(init_done, "R2", "init_done held", init_done, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL R8 watchdog expired: actual 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule